// File: doc/BRIEF.md
# Capture/Compare Counter Array

This block holds one 16-bit counter that several capture/compare channels share (four by default). The counter advances by one on every clock in which a count-enable strobe is high and the software run bit is set. The strobe comes from a clock divider or event source outside the block. Each time the counter wraps from all ones to zero, it raises a sticky overflow flag.

Each channel has a mode register and a 16-bit register. In capture mode, a chosen edge of the channel's input pin copies the counter into the register. The pin is synchronized first, and the edge can be rising, falling or either. In compare mode, the channel sets its flag when the counter steps from a value equal to the register. It can also invert its toggle output on each match, which gives a high-speed square-wave or timed-edge output.

Loading the low byte of a channel register turns its comparator off, and loading the high byte turns it back on. This lets software change a 16-bit compare value one byte at a time without a false match in between. All flags stay set until software clears them. A single interrupt line combines the flags that are enabled.

Top module: `cap_cmp_array`

## Requirements
- R1: After reset every readable register reads 0, `tog_o` is 0 and `irq_o` is 0.
- R2: The counter (low byte at address 2, high byte at address 3) increments by one at each clock edge where `cnt_en_i` is high and the run bit (address 0 bit 0) is 1. Otherwise it holds. A bus write to either counter byte replaces that byte at the next edge and overrides the increment.
- R3: An increment from 0xFFFF to 0x0000 sets the overflow flag (address 1 bit 7).
- R4: Each capture pin passes through a two-flop synchronizer. With positive capture enabled (mode bit 4), a rising pin edge copies the counter into the channel register and sets the channel flag (address 1 bit n). Both happen at the third clock edge after the pin changes.
- R5: With negative capture enabled (mode bit 3), a falling edge captures, with the same latency. With both bits set, either edge captures. With neither bit set, an edge does nothing.
- R6: When comparator enable (mode bit 5) and match (mode bit 2) are both set, a counting step taken while the counter equals the channel register sets the channel flag at that edge.
- R7: When toggle (mode bit 1) is also set, the channel's `tog_o` bit inverts at the same edge as each such match.
- R8: A write to a channel's low register byte (address 8+2n) clears its mode bit 5. A write to its high byte (address 9+2n) sets mode bit 5.
- R9: All flags are sticky. Writing 1 to a bit of address 1 clears that flag. A hardware set in the same cycle as the clear wins.
- R10: `irq_o` is high when any channel flag is set together with that channel's interrupt enable (mode bit 0), or when the overflow flag is set together with the overflow interrupt enable (address 0 bit 1).
- R11: Register map: 0 control {bit1 overflow irq enable, bit0 run}; 1 flags; 2/3 counter; 4+n channel mode; 8+2n / 9+2n channel register low/high. Unused bits and addresses read 0, and `rdata_o` follows `addr_i` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i`, combinational |
| cnt_en_i | input | 1 | Count-enable strobe |
| cap_i | input | 4 | Capture pins, one per channel |
| tog_o | output | 4 | Toggle outputs, one per channel |
| irq_o | output | 1 | Interrupt request |

## Verification
Register writes, counter steps, compare matches, toggles and overflow all show at the first clock edge after the stimulus. Interrupts and read data follow state in the same cycle. Capture results appear only at the third edge after a pin change.

The bench drives inputs on the falling clock edge. A behavioural model updates on the rising edge, and the outputs are compared on the next falling edge, so each result is checked in exactly the cycle it is due. Directed capture checks read the flag one edge early to confirm it is still clear, then again one edge later to confirm it is set.

// File: rtl/cca_pkg.sv
package cca_pkg;
  typedef struct packed {
    logic cmp_en;
    logic cap_pos;
    logic cap_neg;
    logic mat;
    logic tog;
    logic ie;
  } mode_t;

  localparam int MODE_W       = 6;
  localparam int ADDR_CTRL    = 0;
  localparam int ADDR_FLAG    = 1;
  localparam int ADDR_CNT_LO  = 2;
  localparam int ADDR_CNT_HI  = 3;
  localparam int MODE_BASE    = 4;
  localparam int FLAG_OVF_BIT = 7;
endpackage

// File: rtl/cca_sync_edge.sv
module cca_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o =  sync_q[STAGES-1] & ~prev_q;
  assign fall_o = ~sync_q[STAGES-1] &  prev_q;
endmodule

// File: rtl/cca_counter.sv
module cca_counter #(
  parameter int DATA_W = 8,
  localparam int CNT_W = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_lo_i,
  input  logic              wr_hi_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              wrap_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (wr_lo_i) begin
      cnt_q[DATA_W-1:0] <= wdata_i;
    end else if (wr_hi_i) begin
      cnt_q[CNT_W-1:DATA_W] <= wdata_i;
    end else if (tick_i) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = tick_i & (&cnt_q) & ~wr_lo_i & ~wr_hi_i;
endmodule

// File: rtl/cca_channel.sv
module cca_channel
  import cca_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W      = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pin_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              tick_i,
  input  logic              wr_mode_i,
  input  logic              wr_lo_i,
  input  logic              wr_hi_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              flag_clr_i,
  output mode_t             mode_o,
  output logic [CNT_W-1:0]  cap_o,
  output logic              flag_o,
  output logic              tog_o
);
  mode_t            mode_q;
  logic [CNT_W-1:0] cap_q;
  logic             flag_q, tog_q;
  logic             rise, fall, cap_evt, match_evt;

  cca_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pin_i (pin_i),
    .rise_o(rise),
    .fall_o(fall)
  );

  assign cap_evt   = (mode_q.cap_pos & rise) | (mode_q.cap_neg & fall);
  assign match_evt = mode_q.cmp_en & mode_q.mat & tick_i & (cnt_i == cap_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
    end else if (wr_mode_i) begin
      mode_q <= mode_t'(wdata_i[MODE_W-1:0]);
    end else if (wr_lo_i) begin
      mode_q.cmp_en <= 1'b0;   // hold off matches until the pair is loaded
    end else if (wr_hi_i) begin
      mode_q.cmp_en <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_q <= '0;
    end else if (wr_lo_i) begin
      cap_q[DATA_W-1:0] <= wdata_i;
    end else if (wr_hi_i) begin
      cap_q[CNT_W-1:DATA_W] <= wdata_i;
    end else if (cap_evt) begin
      cap_q <= cnt_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      tog_q  <= 1'b0;
    end else begin
      if (cap_evt || match_evt) flag_q <= 1'b1;
      else if (flag_clr_i)      flag_q <= 1'b0;
      if (match_evt && mode_q.tog) tog_q <= ~tog_q;
    end
  end

  assign mode_o = mode_q;
  assign cap_o  = cap_q;
  assign flag_o = flag_q;
  assign tog_o  = tog_q;
endmodule

// File: rtl/cap_cmp_array.sv
module cap_cmp_array
  import cca_pkg::*;
#(
  parameter int NUM_MOD     = 4,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W      = 2 * DATA_W,
  localparam int CAP_BASE   = MODE_BASE + NUM_MOD,
  localparam int ADDR_W     = $clog2(CAP_BASE + 2 * NUM_MOD)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  input  logic               cnt_en_i,
  input  logic [NUM_MOD-1:0] cap_i,
  output logic [NUM_MOD-1:0] tog_o,
  output logic               irq_o
);
  logic               run_q, ovf_ie_q, ovf_flag;
  logic               wr_ctrl, wr_flag, wr_cnt_lo, wr_cnt_hi;
  logic               tick, wrap;
  logic [CNT_W-1:0]   cnt_q;
  mode_t              mode   [NUM_MOD];
  logic [CNT_W-1:0]   cap    [NUM_MOD];
  logic [NUM_MOD-1:0] mod_flag, ie_vec, cmp_en_vec;

  assign wr_ctrl   = wr_en_i && (addr_i == ADDR_W'(ADDR_CTRL));
  assign wr_flag   = wr_en_i && (addr_i == ADDR_W'(ADDR_FLAG));
  assign wr_cnt_lo = wr_en_i && (addr_i == ADDR_W'(ADDR_CNT_LO));
  assign wr_cnt_hi = wr_en_i && (addr_i == ADDR_W'(ADDR_CNT_HI));
  assign tick      = run_q & cnt_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q    <= 1'b0;
      ovf_ie_q <= 1'b0;
    end else if (wr_ctrl) begin
      run_q    <= wdata_i[0];
      ovf_ie_q <= wdata_i[1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              ovf_flag <= 1'b0;
    else if (wrap)                            ovf_flag <= 1'b1;
    else if (wr_flag && wdata_i[FLAG_OVF_BIT]) ovf_flag <= 1'b0;
  end

  cca_counter #(.DATA_W(DATA_W)) u_counter (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick),
    .wr_lo_i(wr_cnt_lo),
    .wr_hi_i(wr_cnt_hi),
    .wdata_i(wdata_i),
    .cnt_o  (cnt_q),
    .wrap_o (wrap)
  );

  for (genvar g = 0; g < NUM_MOD; g++) begin : g_chan
    logic wr_mode, wr_lo, wr_hi;
    assign wr_mode = wr_en_i && (addr_i == ADDR_W'(MODE_BASE + g));
    assign wr_lo   = wr_en_i && (addr_i == ADDR_W'(CAP_BASE + 2 * g));
    assign wr_hi   = wr_en_i && (addr_i == ADDR_W'(CAP_BASE + 2 * g + 1));

    cca_channel #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .pin_i     (cap_i[g]),
      .cnt_i     (cnt_q),
      .tick_i    (tick),
      .wr_mode_i (wr_mode),
      .wr_lo_i   (wr_lo),
      .wr_hi_i   (wr_hi),
      .wdata_i   (wdata_i),
      .flag_clr_i(wr_flag & wdata_i[g]),
      .mode_o    (mode[g]),
      .cap_o     (cap[g]),
      .flag_o    (mod_flag[g]),
      .tog_o     (tog_o[g])
    );

    assign ie_vec[g]     = mode[g].ie;
    assign cmp_en_vec[g] = mode[g].cmp_en;
  end

  assign irq_o = (|(mod_flag & ie_vec)) | (ovf_flag & ovf_ie_q);

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(ADDR_CTRL)) rdata_o[1:0] = {ovf_ie_q, run_q};
    if (addr_i == ADDR_W'(ADDR_FLAG)) begin
      rdata_o[NUM_MOD-1:0]  = mod_flag;
      rdata_o[FLAG_OVF_BIT] = ovf_flag;
    end
    if (addr_i == ADDR_W'(ADDR_CNT_LO)) rdata_o = cnt_q[DATA_W-1:0];
    if (addr_i == ADDR_W'(ADDR_CNT_HI)) rdata_o = cnt_q[CNT_W-1:DATA_W];
    for (int k = 0; k < NUM_MOD; k++) begin
      if (addr_i == ADDR_W'(MODE_BASE + k))      rdata_o[MODE_W-1:0] = mode[k];
      if (addr_i == ADDR_W'(CAP_BASE + 2 * k))     rdata_o = cap[k][DATA_W-1:0];
      if (addr_i == ADDR_W'(CAP_BASE + 2 * k + 1)) rdata_o = cap[k][CNT_W-1:DATA_W];
    end
  end
endmodule

// File: rtl/cap_cmp_array_chk.sv
module cap_cmp_array_chk #(
  parameter int NUM_MOD  = 4,
  parameter int CNT_W    = 16,
  parameter int ADDR_W   = 4,
  parameter int CAP_BASE = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               wr_en_i,
  input logic [ADDR_W-1:0]  addr_i,
  input logic               cnt_en_i,
  input logic [NUM_MOD-1:0] tog_o,
  input logic               irq_o,
  input logic               run_i,
  input logic [CNT_W-1:0]   cnt_i,
  input logic [NUM_MOD-1:0] flag_i,
  input logic               ovf_i,
  input logic [NUM_MOD-1:0] cmp_en_i
);
  logic cnt_wr, flag_wr;
  assign cnt_wr  = wr_en_i && (addr_i == ADDR_W'(2) || addr_i == ADDR_W'(3));
  assign flag_wr = wr_en_i && (addr_i == ADDR_W'(1));

  p_cnt_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && cnt_en_i && !cnt_wr) |=> cnt_i == $past(cnt_i) + CNT_W'(1));

  p_cnt_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(run_i && cnt_en_i) && !cnt_wr) |=> $stable(cnt_i));

  p_ovf_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && cnt_en_i && !cnt_wr && (&cnt_i)) |=> ovf_i);

  p_flag_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flag_wr |=> ((flag_i & $past(flag_i)) == $past(flag_i)));

  p_tog_with_flag_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(tog_o) |-> (((tog_o ^ $past(tog_o)) & ~flag_i) == '0));

  p_irq_source_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (flag_i != '0 || ovf_i));

  for (genvar g = 0; g < NUM_MOD; g++) begin : g_mod
    p_lo_clears_cmp_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && addr_i == ADDR_W'(CAP_BASE + 2 * g)) |=> !cmp_en_i[g]);
    p_hi_sets_cmp_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && addr_i == ADDR_W'(CAP_BASE + 2 * g + 1)) |=> cmp_en_i[g]);
  end
endmodule

bind cap_cmp_array cap_cmp_array_chk #(
  .NUM_MOD (NUM_MOD),
  .CNT_W   (CNT_W),
  .ADDR_W  (ADDR_W),
  .CAP_BASE(CAP_BASE)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .wr_en_i (wr_en_i),
  .addr_i  (addr_i),
  .cnt_en_i(cnt_en_i),
  .tog_o   (tog_o),
  .irq_o   (irq_o),
  .run_i   (run_q),
  .cnt_i   (cnt_q),
  .flag_i  (mod_flag),
  .ovf_i   (ovf_flag),
  .cmp_en_i(cmp_en_vec)
);

// File: tb/cap_cmp_array_bench.sv
module cap_cmp_array_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [3:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       cnt_en_i = 1'b0;
  logic [3:0] cap_i = '0;
  logic [3:0] tog_o;
  logic       irq_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  cap_cmp_array u_cap_cmp_array (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .cnt_en_i(cnt_en_i),
    .cap_i(cap_i), .tog_o(tog_o), .irq_o(irq_o)
  );

  // behavioural reference model
  bit       m_run, m_oie, m_ovf;
  int       m_cnt;
  bit [5:0] m_mode [4];
  int       m_cap  [4];
  bit       m_flag [4];
  bit       m_tog  [4];
  bit       m_s1 [4], m_s2 [4], m_pv [4];

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_run = 0; m_oie = 0; m_ovf = 0; m_cnt = 0;
      for (int k = 0; k < 4; k++) begin
        m_mode[k] = 0; m_cap[k] = 0; m_flag[k] = 0; m_tog[k] = 0;
        m_s1[k] = 0; m_s2[k] = 0; m_pv[k] = 0;
      end
    end else begin
      bit tick, cwr, wrapped;
      tick    = m_run && cnt_en_i;
      cwr     = wr_en_i && (addr_i == 2 || addr_i == 3);
      wrapped = tick && m_cnt == 16'hFFFF && !cwr;
      for (int k = 0; k < 4; k++) begin
        bit r, f, cev, mev, wl, wh;
        r   = m_s2[k] && !m_pv[k];
        f   = !m_s2[k] && m_pv[k];
        cev = (m_mode[k][4] && r) || (m_mode[k][3] && f);
        mev = m_mode[k][5] && m_mode[k][2] && tick && (m_cnt == m_cap[k]);
        wl  = wr_en_i && addr_i == 4'(8 + 2 * k);
        wh  = wr_en_i && addr_i == 4'(9 + 2 * k);
        if (cev || mev) m_flag[k] = 1;
        else if (wr_en_i && addr_i == 1 && wdata_i[k]) m_flag[k] = 0;
        if (mev && m_mode[k][1]) m_tog[k] = !m_tog[k];
        if (wl)       m_cap[k] = (m_cap[k] & 16'hFF00) | wdata_i;
        else if (wh)  m_cap[k] = (m_cap[k] & 16'h00FF) | (int'(wdata_i) << 8);
        else if (cev) m_cap[k] = m_cnt;
        if (wr_en_i && addr_i == 4'(4 + k)) m_mode[k] = wdata_i[5:0];
        else if (wl) m_mode[k][5] = 0;
        else if (wh) m_mode[k][5] = 1;
        m_pv[k] = m_s2[k]; m_s2[k] = m_s1[k]; m_s1[k] = cap_i[k];
      end
      if (wr_en_i && addr_i == 2)      m_cnt = (m_cnt & 16'hFF00) | wdata_i;
      else if (wr_en_i && addr_i == 3) m_cnt = (m_cnt & 16'h00FF) | (int'(wdata_i) << 8);
      else if (tick)                   m_cnt = (m_cnt + 1) & 16'hFFFF;
      if (wrapped) m_ovf = 1;
      else if (wr_en_i && addr_i == 1 && wdata_i[7]) m_ovf = 0;
      if (wr_en_i && addr_i == 0) begin m_run = wdata_i[0]; m_oie = wdata_i[1]; end
    end
  end

  function automatic logic [7:0] m_read(input logic [3:0] a);
    logic [7:0] v = 0;
    case (a)
      0: v = {6'b0, m_oie, m_run};
      1: v = {m_ovf, 3'b0, m_flag[3], m_flag[2], m_flag[1], m_flag[0]};
      2: v = m_cnt[7:0];
      3: v = m_cnt[15:8];
      4, 5, 6, 7: v = {2'b0, m_mode[a-4]};
      default: v = (a[0]) ? m_cap[(a-8)/2][15:8] : m_cap[(a-8)/2][7:0];
    endcase
    return v;
  endfunction

  function automatic bit m_irq();
    bit v = m_ovf && m_oie;
    for (int k = 0; k < 4; k++) if (m_flag[k] && m_mode[k][0]) v = 1;
    return v;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk_i) if (rst_ni && !done) begin
    bit [3:0] et;
    for (int k = 0; k < 4; k++) et[k] = m_tog[k];
    chk("R7 tog_o", tog_o, et);
    chk("R10 irq_o", irq_o, m_irq());
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk_i);
    wr_en_i = 1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 0;
  endtask

  task automatic rd(input logic [3:0] a, input string tag);
    addr_i = a; #1;
    chk(tag, rdata_o, m_read(a));
  endtask

  task automatic rd_lit(input logic [3:0] a, input logic [7:0] mask, input logic [7:0] exp, input string tag);
    addr_i = a; #1;
    chk(tag, rdata_o & mask, exp);
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic report();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    int c0;
    cyc(3);
    rst_ni = 1;
    @(negedge clk_i);
    // R1 reset state
    for (int a = 0; a < 16; a++) rd_lit(4'(a), 8'hFF, 8'h00, "R1 reset read");
    chk("R1 tog_o reset", tog_o, 0);
    chk("R1 irq_o reset", irq_o, 0);

    // R2 counting
    wr(0, 8'h01);
    cnt_en_i = 1; cyc(10); cnt_en_i = 0; cyc(1);
    rd_lit(2, 8'hFF, 8'd10, "R2 count of ten");
    cyc(3);
    rd_lit(2, 8'hFF, 8'd10, "R2 hold without strobe");
    wr(2, 8'h80); rd_lit(2, 8'hFF, 8'h80, "R2 counter low write");

    // R4 rising capture latency
    c0 = m_cnt;
    wr(4, 8'h10);
    cap_i[0] = 1; cyc(2);
    rd_lit(1, 8'h01, 8'h00, "R4 flag not yet at edge two");
    cyc(1);
    rd_lit(1, 8'h01, 8'h01, "R4 flag at edge three");
    rd_lit(8, 8'hFF, 8'(c0), "R4 captured value");
    cap_i[0] = 0; cyc(4);
    wr(1, 8'h0F);

    // R5 falling and both-edge capture
    wr(5, 8'h08); wr(6, 8'h18);
    cap_i[1] = 1; cap_i[2] = 1; cyc(4);
    rd_lit(1, 8'h06, 8'h04, "R5 rise: only both-edge channel");
    wr(1, 8'h0F);
    cap_i[1] = 0; cap_i[2] = 0; cyc(4);
    rd_lit(1, 8'h06, 8'h06, "R5 fall: both channels");
    rd(10, "R5 capture value ch1");
    wr(1, 8'h0F);

    // R8 byte writes gate the comparator; R6/R7 match
    wr(7, 8'h27);
    wr(2, 8'h40); wr(3, 8'h00);
    wr(14, 8'h45);
    rd_lit(7, 8'hFF, 8'h07, "R8 low write clears enable");
    wr(15, 8'h00);
    rd_lit(7, 8'hFF, 8'h27, "R8 high write sets enable");
    wr(1, 8'h0F);
    cnt_en_i = 1; cyc(5);
    chk("R7 no toggle before match", tog_o[3], 0);
    cyc(1); cnt_en_i = 0;
    chk("R7 toggle on match", tog_o[3], 1);
    rd_lit(1, 8'h08, 8'h08, "R6 match flag");
    chk("R10 irq from channel", irq_o, 1);

    // R9 set beats clear
    wr(2, 8'h45);
    @(negedge clk_i);
    wr_en_i = 1; addr_i = 1; wdata_i = 8'h08; cnt_en_i = 1;
    @(negedge clk_i);
    wr_en_i = 0; cnt_en_i = 0;
    rd_lit(1, 8'h08, 8'h08, "R9 hardware set wins");
    wr(1, 8'h08);
    rd_lit(1, 8'h08, 8'h00, "R9 software clear");

    // R3 overflow, R10 overflow irq
    wr(7, 8'h00);
    wr(3, 8'hFF); wr(2, 8'hFE);
    cnt_en_i = 1; cyc(2); cnt_en_i = 0;
    rd_lit(1, 8'h80, 8'h80, "R3 overflow flag");
    rd_lit(2, 8'hFF, 8'h00, "R3 wrapped to zero");
    cyc(3);
    rd_lit(1, 8'h80, 8'h80, "R9 overflow sticky");
    wr(0, 8'h03);
    chk("R10 overflow irq", irq_o, 1);
    wr(1, 8'h80);
    chk("R10 irq drops after clear", irq_o, 0);

    // randomized traffic against the model
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk_i);
      cnt_en_i = ($urandom % 4) != 0;
      if ($urandom % 8 == 0) cap_i[$urandom % 4] ^= 1'b1;
      wr_en_i = ($urandom % 10) == 0;
      addr_i  = 4'($urandom);
      wdata_i = 8'($urandom);
      if (wr_en_i && addr_i == 0) wdata_i[0] = 1'b1;
      #1;
      chk("R11 read map", rdata_o, m_read(addr_i));
    end
    wr_en_i = 0;
    cyc(2);
    report();
  end
endmodule